// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits on the host side of a serial NOR flash. It takes one request at a time from the user side and produces the command frames needed on a four-wire SPI link. A request carries an operation code, a 24-bit start address and a byte length. Read data leaves on a byte stream with valid/ready handshaking. Program data enters on a second stream that uses the same handshake. A one-cycle `done` pulse (with the count of data bytes moved) or a one-cycle `err` pulse ends every accepted request.

Each step of work is preceded by status polling. A step is one read frame, one program chunk, or one erased sector. The step is gated on the device's write-in-progress flag. Program and erase steps are also preceded by a separate write-enable frame. Programs are cut at page boundaries, and each piece is issued as its own program command. An erase range is walked one sector at a time.

The controller is one state machine:
- IDLE moves to CHECK when a request arrives.
- CHECK goes to FINISH for a zero-length request, to FAIL for an illegal one, and otherwise to POLL_OP.
- POLL_OP (status opcode) moves to POLL_RX (status byte) and then to POLL_EVAL.
- POLL_EVAL loops back to POLL_OP while the device is busy, goes to FAIL at the poll limit, and when the device is ready goes either to CMD (read) or to WREN followed by WREN_GAP and then CMD (program and erase).
- CMD sends the opcode and three address bytes. From there a read or program goes to DATA and then CHUNK_END, and an erase goes to ERASE_STEP.
- CHUNK_END and ERASE_STEP return to POLL_OP while bytes or sectors remain, and go to FINISH otherwise.
- FINISH and FAIL both return to IDLE.

Top module: `spinor_seq`

## Requirements
- R1: Read, program and erase frames begin with opcode 0x03, 0x02 or 0xD8 respectively, followed by the 24-bit address most significant byte first. Data bytes of a read or program follow in the same chip-select-low frame.
- R2: Before every read frame, every program chunk and every erased sector, the block issues status frames (opcode 0x05 plus one response byte) until a response has bit 0 clear.
- R3: If POLL_LIMIT consecutive status responses all have bit 0 set, the block pulses `err` and issues no command frame for that request.
- R4: Every program frame and every erase frame is directly preceded by a one-byte frame carrying 0x06.
- R5: Program data is split at PAGE_BYTES boundaries. The first chunk holds the lesser of the remaining length and the bytes left in the start page. Later chunks hold at most PAGE_BYTES bytes and start at the running address.
- R6: An erase whose address or length is not a multiple of SECTOR_BYTES pulses `err` without any SPI frame.
- R7: A request whose address plus length exceeds DEV_BYTES pulses `err` without any frame. A range that ends exactly at DEV_BYTES is accepted. The encoding of `req_op` is 0 read, 1 program, 2 erase; value 3 is rejected with `err`.
- R8: A zero-length request raises `done` with count 0 two cycles after acceptance, without any frame.
- R9: A multi-sector erase issues one 0xD8 frame per sector, with the address advancing by SECTOR_BYTES each time.
- R10: The link runs SPI mode 0, most significant bit first. `sck` is low whenever `cs_n` is high, and `cs_n` only changes while `sck` is low.
- R11: `done_count` equals the number of data bytes moved (zero for erase). `done` and `err` are one-cycle pulses that never coincide, and the block is idle in the following cycle.
- R12: Read bytes appear in address order, and `rd_valid` and `rd_data` hold until `rd_ready`. Program bytes are taken in order on `wr_valid && wr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while not busy |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Program byte accepted this cycle if valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Rejection or poll timeout pulse |
| done_count | output | LEN_W | Data bytes moved by the finished request |
| sck | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench focuses on page-boundary splitting. It uses a start 240 bytes into a page, a five-byte write straddling a boundary, and an exact full page. A wrong chunk formula shows up as a wrong length or address in a program frame, or as a frame that wraps within a page. Status polls are forced to report busy for several responses and then indefinitely. A design that skips polling, or that miscounts the limit, issues commands to a busy device or gives a different number of status frames before `err`. The range edge is probed at exactly the device end and one past it, alongside misaligned erases and the unused op code. Read backpressure and program stalls check that no byte is lost or repeated.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_t;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_RDSR = 8'h05;
    localparam logic [7:0] CMD_READ = 8'h03;
    localparam logic [7:0] CMD_PP   = 8'h02;
    localparam logic [7:0] CMD_SE   = 8'hD8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_POLL_OP,
        ST_POLL_RX,
        ST_POLL_EVAL,
        ST_WREN,
        ST_WREN_GAP,
        ST_CMD,
        ST_DATA,
        ST_CHUNK_END,
        ST_ERASE_STEP,
        ST_FINISH,
        ST_FAIL
    } seq_state_t;

endpackage

// File: rtl/spinor_shifter.sv
module spinor_shifter #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DW-1:0] DIV_TOP = DW'(SCK_HALF - 1);

    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          act_q;
    logic          sck_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            act_q  <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                sh_q  <= tx_byte;
                bit_q <= '0;
                div_q <= '0;
                act_q <= 1'b1;
                sck_q <= 1'b0;
            end else if (act_q) begin
                if (div_q == DIV_TOP) begin
                    div_q <= '0;
                    sck_q <= ~sck_q;
                    if (!sck_q) begin
                        rx_q <= {rx_q[6:0], miso};
                    end else if (bit_q == 3'd7) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
        end
    end

    assign rx_byte   = rx_q;
    assign byte_done = done_q;
    assign sck       = sck_q;
    assign mosi      = sh_q[7];

endmodule

// File: rtl/spinor_reqchk.sv
module spinor_reqchk
    import spinor_pkg::*;
#(
    parameter int LEN_W        = 24,
    parameter int DEV_BYTES    = 1 << 20,
    parameter int SECTOR_BYTES = 65536
) (
    input  op_t                op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LEN_W-1:0]   len,
    output logic               zero,
    output logic               ok
);
    localparam int SW = $clog2(SECTOR_BYTES);
    localparam int EW = ((LEN_W > ADDR_W) ? LEN_W : ADDR_W) + 1;

    logic [EW-1:0] end_a;
    logic          op_valid;
    logic          in_range;
    logic          aligned;

    always_comb begin
        end_a    = EW'(addr) + EW'(len);
        in_range = (end_a <= EW'(DEV_BYTES));
        aligned  = (addr[SW-1:0] == '0) && (len[SW-1:0] == '0);
        op_valid = (op == OP_RD) || (op == OP_PROG) || (op == OP_ERASE);
        zero     = op_valid && (len == '0);
        ok       = op_valid && in_range && ((op != OP_ERASE) || aligned);
    end

endmodule

// File: rtl/spinor_chunk.sv
module spinor_chunk #(
    parameter int LEN_W      = 24,
    parameter int PAGE_BYTES = 256
) (
    input  logic [$clog2(PAGE_BYTES)-1:0] addr_lo,
    input  logic [LEN_W-1:0]              remain,
    output logic [LEN_W-1:0]              chunk
);
    localparam int PGW = $clog2(PAGE_BYTES);

    logic [PGW:0] room;

    always_comb begin
        room  = (PGW+1)'(PAGE_BYTES) - {1'b0, addr_lo};
        chunk = (remain < LEN_W'(room)) ? remain : LEN_W'(room);
    end

endmodule

// File: rtl/spinor_seq.sv
module spinor_seq
    import spinor_pkg::*;
#(
    parameter int LEN_W        = 24,
    parameter int DEV_BYTES    = 1 << 20,
    parameter int SECTOR_BYTES = 65536,
    parameter int PAGE_BYTES   = 256,
    parameter int SCK_HALF     = 2,
    parameter int POLL_LIMIT   = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [LEN_W-1:0]  done_count,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int PW  = $clog2(POLL_LIMIT + 1);
    localparam int PGW = $clog2(PAGE_BYTES);
    localparam logic [PW-1:0]     POLL_TOP = PW'(POLL_LIMIT);
    localparam logic [LEN_W-1:0]  SEC_LEN  = LEN_W'(SECTOR_BYTES);
    localparam logic [ADDR_W-1:0] SEC_ADR  = ADDR_W'(SECTOR_BYTES);

    seq_state_t        state_q, state_d;
    op_t               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [LEN_W-1:0]  moved_q;
    logic [PW-1:0]     poll_q;
    logic [1:0]        idx_q;
    logic              launched_q;
    logic              rdv_q;
    logic [7:0]        rdat_q;
    logic              stat_busy_q;
    logic              cs_n_q;

    logic              sh_start;
    logic [7:0]        sh_tx;
    logic [7:0]        sh_rx;
    logic              sh_done;
    logic              chk_zero;
    logic              chk_ok;
    logic [LEN_W-1:0]  chunk_w;
    logic [7:0]        cmd_op;

    spinor_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
        .rx_byte(sh_rx), .byte_done(sh_done), .sck(sck), .mosi(mosi), .miso(miso)
    );

    spinor_reqchk #(.LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_chk_req (
        .op(op_q), .addr(addr_q), .len(remain_q), .zero(chk_zero), .ok(chk_ok)
    );

    spinor_chunk #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .addr_lo(addr_q[PGW-1:0]), .remain(remain_q), .chunk(chunk_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (chk_zero)     state_d = ST_FINISH;
                else if (!chk_ok) state_d = ST_FAIL;
                else              state_d = ST_POLL_OP;
            end
            ST_POLL_OP:    if (sh_done) state_d = ST_POLL_RX;
            ST_POLL_RX:    if (sh_done) state_d = ST_POLL_EVAL;
            ST_POLL_EVAL: begin
                if (!stat_busy_q)          state_d = (op_q == OP_RD) ? ST_CMD : ST_WREN;
                else if (poll_q == POLL_TOP) state_d = ST_FAIL;
                else                       state_d = ST_POLL_OP;
            end
            ST_WREN:       if (sh_done) state_d = ST_WREN_GAP;
            ST_WREN_GAP:   state_d = ST_CMD;
            ST_CMD:        if (sh_done && idx_q == 2'd3)
                               state_d = (op_q == OP_ERASE) ? ST_ERASE_STEP : ST_DATA;
            ST_DATA:       if (sh_done && chunk_q == LEN_W'(1)) state_d = ST_CHUNK_END;
            ST_CHUNK_END:  if (!rdv_q) state_d = (remain_q == '0) ? ST_FINISH : ST_POLL_OP;
            ST_ERASE_STEP: state_d = (remain_q == '0) ? ST_FINISH : ST_POLL_OP;
            ST_FINISH:     state_d = ST_IDLE;
            ST_FAIL:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            op_q        <= OP_RD;
            addr_q      <= '0;
            remain_q    <= '0;
            chunk_q     <= '0;
            moved_q     <= '0;
            poll_q      <= '0;
            idx_q       <= '0;
            launched_q  <= 1'b0;
            rdv_q       <= 1'b0;
            rdat_q      <= '0;
            stat_busy_q <= 1'b0;
            cs_n_q      <= 1'b1;
        end else begin
            state_q <= state_d;
            cs_n_q  <= !(state_d inside {ST_POLL_OP, ST_POLL_RX, ST_WREN, ST_CMD, ST_DATA});
            if (sh_start)     launched_q <= 1'b1;
            else if (sh_done) launched_q <= 1'b0;
            if (rdv_q && rd_ready) rdv_q <= 1'b0;

            if (state_q == ST_IDLE && req_valid) begin
                op_q     <= op_t'(req_op);
                addr_q   <= req_addr;
                remain_q <= req_len;
                moved_q  <= '0;
            end
            if (state_d == ST_POLL_OP &&
                state_q inside {ST_CHECK, ST_CHUNK_END, ST_ERASE_STEP})
                poll_q <= '0;
            if (state_q == ST_POLL_RX && sh_done) begin
                poll_q      <= poll_q + PW'(1);
                stat_busy_q <= sh_rx[0];
            end
            if (state_q == ST_CMD && sh_done) begin
                idx_q <= idx_q + 2'd1;
                if (idx_q == 2'd3) begin
                    if (op_q == OP_ERASE) begin
                        addr_q   <= addr_q + SEC_ADR;
                        remain_q <= remain_q - SEC_LEN;
                    end else begin
                        chunk_q <= (op_q == OP_RD) ? remain_q : chunk_w;
                    end
                end
            end
            if (state_q == ST_DATA && sh_done) begin
                chunk_q  <= chunk_q - LEN_W'(1);
                remain_q <= remain_q - LEN_W'(1);
                addr_q   <= addr_q + ADDR_W'(1);
                moved_q  <= moved_q + LEN_W'(1);
                if (op_q == OP_RD) begin
                    rdv_q  <= 1'b1;
                    rdat_q <= sh_rx;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (op_q)
            OP_RD:   cmd_op = CMD_READ;
            OP_PROG: cmd_op = CMD_PP;
            default: cmd_op = CMD_SE;
        endcase
        sh_tx    = 8'h00;
        sh_start = 1'b0;
        wr_ready = 1'b0;
        unique case (state_q)
            ST_POLL_OP: begin sh_tx = CMD_RDSR; sh_start = !launched_q; end
            ST_POLL_RX: begin sh_tx = 8'h00;    sh_start = !launched_q; end
            ST_WREN:    begin sh_tx = CMD_WREN; sh_start = !launched_q; end
            ST_CMD: begin
                unique case (idx_q)
                    2'd0: sh_tx = cmd_op;
                    2'd1: sh_tx = addr_q[23:16];
                    2'd2: sh_tx = addr_q[15:8];
                    default: sh_tx = addr_q[7:0];
                endcase
                sh_start = !launched_q;
            end
            ST_DATA: begin
                if (op_q == OP_PROG) begin
                    wr_ready = !launched_q;
                    sh_tx    = wr_data;
                    sh_start = !launched_q && wr_valid;
                end else begin
                    sh_start = !launched_q && !rdv_q;
                end
            end
            default: ;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FINISH);
    assign err        = (state_q == ST_FAIL);
    assign done_count = moved_q;
    assign rd_valid   = rdv_q;
    assign rd_data    = rdat_q;
    assign cs_n       = cs_n_q;

endmodule

// File: rtl/spinor_seq_chk.sv
module spinor_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       wr_ready,
    input logic [7:0] rd_data
);
    p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_cs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) || $fell(cs_n)) |-> !sck);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    p_end_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !busy);

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_wr_in_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !cs_n);

endmodule

bind spinor_seq spinor_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .busy(busy),
    .done(done), .err(err), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_ready(wr_ready), .rd_data(rd_data)
);

// File: tb/sim_spinor_seq.sv
module sim_spinor_seq;
    localparam int LEN_W = 16;
    localparam int DEV   = 4096;
    localparam int SEC   = 1024;
    localparam int PLIM  = 6;

    typedef struct {
        logic [7:0] op;
        int         addr;
        int         n;
        int         d0;
    } frm_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0] wr_data;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [7:0] rd_data;
    logic rd_valid;
    logic rd_ready = 1'b0;
    logic busy, done, err;
    logic [LEN_W-1:0] done_count;
    logic sck, cs_n, mosi, miso;

    int nchk = 0;
    int nerr = 0;
    int wr_idx = 0;
    int cyc = 0;

    frm_t       exp_q[$];
    logic [7:0] exp_rd[$];

    // flash model state
    logic [7:0] fb[$];
    logic [7:0] m_out = 8'hFF;
    logic [7:0] m_cur = 8'h00;
    int m_bit = 0;
    int busy_left = 0;
    int stat_frames = 0;
    int op_frames = 0;
    bit ready_seen = 0;
    bit last_ready = 0;
    logic [7:0] prev_op = 8'h00;

    always #4 clk = ~clk;

    assign wr_data = 8'(wr_idx * 7 + 1);

    spinor_seq #(.LEN_W(LEN_W), .DEV_BYTES(DEV), .SECTOR_BYTES(SEC),
                 .PAGE_BYTES(256), .SCK_HALF(1), .POLL_LIMIT(PLIM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy), .done(done),
        .err(err), .done_count(done_count), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    function automatic logic [7:0] rd_pat(int a);
        return 8'(a) ^ 8'hA5 ^ 8'(a >> 8);
    endfunction

    task automatic check(string tag, int act, int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic expect_frame(logic [7:0] op, int addr, int n, int d0);
        frm_t f;
        f.op = op; f.addr = addr; f.n = n; f.d0 = d0;
        exp_q.push_back(f);
    endtask

    // ---------------- flash model ----------------
    assign miso = cs_n ? 1'b0 : m_out[3'(7 - m_bit)];

    always @(negedge cs_n) begin
        m_bit = 0;
        m_out = 8'hFF;
        fb.delete();
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            m_cur = {m_cur[6:0], mosi};
            m_bit++;
            if (m_bit == 8) begin
                m_bit = 0;
                fb.push_back(m_cur);
                m_out = 8'hFF;
                if (fb[0] == 8'h05 && fb.size() == 1) begin
                    m_out = (busy_left > 0) ? 8'h01 : 8'h00;
                    last_ready = (busy_left == 0);
                    if (busy_left > 0) busy_left--;
                end else if (fb[0] == 8'h03 && fb.size() >= 4) begin
                    m_out = rd_pat(int'({fb[1], fb[2], fb[3]}) + fb.size() - 4);
                end
            end
        end
    end

    // scoreboard monitor for command frames
    always @(posedge cs_n) begin
        if (fb.size() > 0) begin
            if (fb[0] == 8'h05) begin
                stat_frames++;
                if (last_ready) ready_seen = 1;
            end else begin
                op_frames++;
                nchk++;
                if (exp_q.size() == 0) begin
                    nerr++;
                    $display("FAIL R1: got unexpected frame op %0h expected none", fb[0]);
                end else begin
                    frm_t e;
                    bit good;
                    e = exp_q.pop_front();
                    good = (fb[0] == e.op);
                    if (e.op == 8'h06) good = good && (fb.size() == 1);
                    else begin
                        good = good && (fb.size() >= 4) &&
                               (int'({fb[1], fb[2], fb[3]}) == e.addr) &&
                               (fb.size() - 4 == e.n);
                        if (good && e.op == 8'h02)
                            for (int k = 0; k < e.n; k++)
                                if (fb[4 + k] != 8'((e.d0 + k) * 7 + 1)) good = 0;
                    end
                    if (!good) begin
                        nerr++;
                        $display("FAIL R1/R5/R9: got op %0h addr %0h n %0d expected op %0h addr %0h n %0d",
                                 fb[0], (fb.size() >= 4) ? int'({fb[1], fb[2], fb[3]}) : -1,
                                 int'(fb.size()) - 4, e.op, e.addr, e.n);
                    end
                end
                if (fb[0] == 8'h02 || fb[0] == 8'hD8) begin
                    check("R4 write enable precedes", prev_op, 8'h06);
                    busy_left = 2;
                end
                if (fb[0] == 8'h02 || fb[0] == 8'h03 || fb[0] == 8'hD8) begin
                    check("R2 ready poll before command", ready_seen, 1);
                    ready_seen = 0;
                end
                prev_op = fb[0];
            end
        end
    end

    // program data driver
    initial begin
        forever begin
            @(negedge clk);
            wr_valid = (cyc % 5 != 0);
            #1;
            if (wr_valid && wr_ready) begin
                @(posedge clk);
                #1;
                wr_idx++;
            end
        end
    end

    // read data monitor with backpressure
    initial begin
        forever begin
            @(negedge clk);
            rd_ready = (cyc % 3 != 0);
            #1;
            if (rd_valid && rd_ready) begin
                nchk++;
                if (exp_rd.size() == 0) begin
                    nerr++;
                    $display("FAIL R12: got extra read byte %0h expected none", rd_data);
                end else begin
                    logic [7:0] eb;
                    eb = exp_rd.pop_front();
                    if (rd_data != eb) begin
                        nerr++;
                        $display("FAIL R12: got %0h expected %0h", rd_data, eb);
                    end
                end
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    task automatic issue(logic [1:0] op, int addr, int len);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = 24'(addr);
        req_len   = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(output bit d, output bit e, output int cnt, output int n);
        d = 0; e = 0; cnt = 0; n = 0;
        while (!d && !e && n < 60000) begin
            @(negedge clk);
            n++;
            d = done; e = err; cnt = int'(done_count);
        end
    endtask

    task automatic run(string tag, logic [1:0] op, int addr, int len,
                       bit want_err, int want_cnt);
        bit d, e;
        int cnt, n, of0;
        of0 = op_frames;
        wr_idx = 0;
        issue(op, addr, len);
        wait_end(d, e, cnt, n);
        repeat (3) @(negedge clk);
        check({tag, " end kind"}, want_err ? int'(e) : int'(d), 1);
        if (!want_err) check({"R11 ", tag, " count"}, cnt, want_cnt);
        check({tag, " expected frames left"}, exp_q.size(), 0);
        if (want_err) check({tag, " frames on reject"}, op_frames - of0, 0);
    endtask

    initial begin
        bit d, e;
        int cnt, n, s0;
        repeat (4) @(negedge clk);
        check("R10 reset cs_n", cs_n, 1);
        check("R10 reset sck", sck, 0);
        check("R11 reset busy", busy, 0);
        check("R11 reset done", done, 0);
        check("R11 reset err", err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle cs_n", cs_n, 1);

        // R1 R2 R12: read with busy polls
        busy_left = 3;
        s0 = stat_frames;
        expect_frame(8'h03, 24'h123, 8, 0);
        for (int k = 0; k < 8; k++) exp_rd.push_back(rd_pat(24'h123 + k));
        run("R1 read", 2'd0, 24'h123, 8, 0, 8);
        check("R2 status frames before read", stat_frames - s0, 4);
        check("R12 read bytes drained", exp_rd.size(), 0);

        // R5: program crossing two page boundaries
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'h02, 24'h0F0, 16, 0);
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'h02, 24'h100, 256, 16);
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'h02, 24'h200, 28, 272);
        run("R5 program 300", 2'd1, 24'h0F0, 300, 0, 300);

        // R5: short program straddling a boundary
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'h02, 24'h3FE, 2, 0);
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'h02, 24'h400, 3, 2);
        run("R5 program straddle", 2'd1, 24'h3FE, 5, 0, 5);

        // R5: exact page
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'h02, 24'h500, 256, 0);
        run("R5 program full page", 2'd1, 24'h500, 256, 0, 256);

        // R9: two-sector erase
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'hD8, 24'h400, 0, 0);
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'hD8, 24'h800, 0, 0);
        run("R9 erase two sectors", 2'd2, 24'h400, 24'h800, 0, 0);

        // R7: erase ending exactly at device end accepted
        expect_frame(8'h06, 0, 0, 0); expect_frame(8'hD8, 24'hC00, 0, 0);
        run("R7 erase last sector", 2'd2, 24'hC00, 24'h400, 0, 0);

        // R6: misaligned erase
        run("R6 erase misaligned addr", 2'd2, 24'h100, 24'h400, 1, 0);
        run("R6 erase misaligned len", 2'd2, 24'h400, 24'h200, 1, 0);

        // R7: range and op code rejection
        run("R7 read past end", 2'd0, 24'hFF0, 24'h20, 1, 0);
        run("R7 program past end", 2'd1, 24'hFFF, 2, 1, 0);
        run("R7 invalid op", 2'd3, 24'h000, 4, 1, 0);

        // R8: zero-length read completes at once
        s0 = stat_frames;
        issue(2'd0, 24'h010, 0);
        wait_end(d, e, cnt, n);
        check("R8 zero length done", d, 1);
        check("R8 zero length latency", n, 1);
        check("R8 zero length count", cnt, 0);
        repeat (3) @(negedge clk);
        check("R8 zero length no status frame", stat_frames - s0, 0);

        // R3: poll timeout
        busy_left = 1000;
        s0 = stat_frames;
        run("R3 poll timeout", 2'd0, 24'h040, 4, 1, 0);
        check("R3 status reads before giving up", stat_frames - s0, PLIM);
        busy_left = 0;

        // R1 after timeout: device recovers
        expect_frame(8'h03, 24'hFFC, 4, 0);
        for (int k = 0; k < 4; k++) exp_rd.push_back(rd_pat(24'hFFC + k));
        run("R1 read at device end", 2'd0, 24'hFFC, 4, 0, 4);
        check("R12 read bytes drained end", exp_rd.size(), 0);
        check("R10 final cs_n", cs_n, 1);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule